// File: doc/BRIEF.md
# Radio Slot Strobe Sequencer

This block sits on the baseband side of a short-range frequency-hopping radio link. It drives the radio's control strobes for one transmit slot or one receive slot: synthesizer enable, transmit enable, loop-open, receive enable and the packet strobe. A one-cycle start request brings in the slot direction and a packet length of 1, 3 or 5 slots. Channel programming happens on another path. This block only waits for a "channel loaded" level before it begins the slot.

All timing counts 1 MHz ticks, which arrive as a one-cycle enable on the system clock. The slot begins in the cycle that synthesizer enable rises. From then on, every strobe edge is a fixed number of ticks after that point. Each settle delay is a parameter whose default is the typical value. The block also raises a data-window level while payload bits may flow, and a one-cycle pulse at the packet-strobe rise to trigger a signal-strength sample. It pulses slot-end on the final tick of the slot, then drops every strobe and the busy flag.

Top module: `rss_slot_sequencer`

## Requirements
- R1: After reset every output is low and the block is idle.
- R2: A start with length code 0 (1 slot), 1 (3 slots) or 2 (5 slots), seen while idle, is accepted and captures `slot_rx` and `pkt_len`. Synthesizer enable rises in the cycle after the first clock edge at which `chan_loaded` is high, counting from the accepting edge onward. That rise is tick 0 of the slot.
- R3: In a transmit slot (`slot_rx`=0), transmit enable rises once 110 ticks of the slot have passed. It stays high until the slot ends.
- R4: In a transmit slot, loop-open rises 104 ticks after transmit enable (tick 214) and stays high until the slot ends. It is never high without transmit enable.
- R5: In a receive slot (`slot_rx`=1), receive enable rises at tick 208 and stays high until the slot ends. Transmit enable and loop-open stay low in a receive slot, and receive enable stays low in a transmit slot.
- R6: The data window is high from tick 214 (transmit) or tick 213 (receive). It lasts 366, 1622 or 2870 ticks for length code 0, 1 or 2.
- R7: A slot lasts 625, 1875 or 3125 ticks for length code 0, 1 or 2. Slot-end is high in the cycle that carries the last tick. On the next cycle every strobe and busy are low.
- R8: In a receive slot, the packet strobe is high from tick 213 for 72 ticks. The signal-strength sample pulse is high for exactly the one cycle in which the packet strobe first reads high.
- R9: A start seen while busy, or any start with length code 3, has no effect on the slot in progress. It raises the error output for exactly one cycle after that edge.
- R10: Busy is high from the cycle after an accepted start until the cycle after slot-end. Busy is high whenever any strobe is high.
- R11: Clock cycles without a tick do not advance the slot: no strobe changes and slot-end does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | One-cycle enable at 1 MHz |
| start | input | 1 | One-cycle slot request |
| slot_rx | input | 1 | Slot direction: 1 receive, 0 transmit |
| pkt_len | input | 2 | Packet length code: 0, 1, 2 for 1, 3, 5 slots; 3 invalid |
| chan_loaded | input | 1 | Channel word is in the radio; slot may begin |
| synth_en | output | 1 | Synthesizer enable strobe |
| tx_en | output | 1 | Transmit enable strobe |
| loop_open | output | 1 | Open the synthesizer control loop |
| rx_en | output | 1 | Receive enable strobe |
| pkt_strobe | output | 1 | Packet synchronization strobe |
| rssi_sample | output | 1 | One-cycle pulse at packet-strobe rise |
| data_ok | output | 1 | Payload data window |
| slot_end | output | 1 | One-cycle pulse on the final tick of the slot |
| busy | output | 1 | Slot pending or in progress |
| start_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
A wrong tick position shows up as a strobe edge one or more ticks off its expected place. It appears at the ports in the same cycle as the tick that moved it. A wrong sequencer state shows up in busy or synthesizer enable on the very next clock, and an illegal start shows up through the error pulse and an unchanged busy. The bench models the slot from its own tick count, compares every output on every cycle under random tick spacing and random channel-ready delays, and adds a frozen-tick window, rejected starts during a slot and the invalid length code.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_RUN  = 2'd2
  } seq_state_e;

  // packet length codes
  localparam logic [1:0] LEN_1   = 2'd0;
  localparam logic [1:0] LEN_3   = 2'd1;
  localparam logic [1:0] LEN_5   = 2'd2;
  localparam logic [1:0] LEN_BAD = 2'd3;

  // window indices
  localparam int NWIN   = 5;
  localparam int W_TXON = 0;
  localparam int W_LOOP = 1;
  localparam int W_RXON = 2;
  localparam int W_DATA = 3;
  localparam int W_SYNC = 4;

  // slot duration in ticks: odd multiple of one slot period
  function automatic int unsigned slot_ticks(input logic [1:0] code,
                                             input int unsigned per_slot);
    int unsigned n;
    n = 2 * int'(code) + 1;
    return per_slot * n;
  endfunction

  // longest payload period for a length code
  function automatic int unsigned data_ticks(input logic [1:0] code,
                                             input int unsigned d1,
                                             input int unsigned d3,
                                             input int unsigned d5);
    case (code)
      LEN_1:   return d1;
      LEN_3:   return d3;
      default: return d5;
    endcase
  endfunction

endpackage

// File: rtl/rss_slot_timer.sv
module rss_slot_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pos,
  output logic         last
);

  assign last = run && tick && (pos == limit - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      pos <= '0;
    else if (!run)   pos <= '0;
    else if (tick)   pos <= last ? '0 : pos + W'(1);
  end

  // R11: no tick, no progress
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (pos == $past(pos)));

  // R7: position never reaches the slot length
  a_r7_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < limit));

endmodule

// File: rtl/rss_window.sv
module rss_window #(
  parameter int W = 12
) (
  input  logic         en,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] first,
  input  logic [W-1:0] span,
  output logic         on
);

  logic [W:0] stop;

  assign stop = {1'b0, first} + {1'b0, span};
  assign on   = en && (pos >= first) && ({1'b0, pos} < stop);

endmodule

// File: rtl/rss_slot_sequencer.sv
module rss_slot_sequencer
  import rss_pkg::*;
#(
  parameter int SLOT_TICKS   = 625,
  parameter int TX_ON_TICKS  = 110,
  parameter int LOOP_GAP     = 104,
  parameter int TX_DATA_AT   = 214,
  parameter int RX_ON_TICKS  = 208,
  parameter int RX_DATA_AT   = 213,
  parameter int SYNC_TICKS   = 72,
  parameter int DATA1_TICKS  = 366,
  parameter int DATA3_TICKS  = 1622,
  parameter int DATA5_TICKS  = 2870
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       start,
  input  logic       slot_rx,
  input  logic [1:0] pkt_len,
  input  logic       chan_loaded,
  output logic       synth_en,
  output logic       tx_en,
  output logic       loop_open,
  output logic       rx_en,
  output logic       pkt_strobe,
  output logic       rssi_sample,
  output logic       data_ok,
  output logic       slot_end,
  output logic       busy,
  output logic       start_err
);

  localparam int CNT_W = $clog2(5 * SLOT_TICKS + 1);

  seq_state_e       st;
  logic             is_tx_q;
  logic [1:0]       len_q;
  logic             err_q;
  logic             pkt_d;

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] limit;
  logic             last;
  logic             run;

  // named internal events
  logic             len_ok;
  logic             accept;
  logic             reject;

  assign len_ok = (pkt_len != LEN_BAD);
  assign accept = (st == S_IDLE) && start && len_ok;
  assign reject = start && ((st != S_IDLE) || !len_ok);
  assign run    = (st == S_RUN);
  assign limit  = CNT_W'(slot_ticks(len_q, SLOT_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_tx_q <= 1'b0;
      len_q   <= LEN_1;
      err_q   <= 1'b0;
      pkt_d   <= 1'b0;
    end else begin
      err_q <= reject;
      pkt_d <= pkt_strobe;
      case (st)
        S_IDLE: if (accept) begin
          is_tx_q <= !slot_rx;
          len_q   <= pkt_len;
          st      <= chan_loaded ? S_RUN : S_WAIT;
        end
        S_WAIT: if (chan_loaded) st <= S_RUN;
        S_RUN:  if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  rss_slot_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick_1us),
    .limit (limit),
    .pos   (pos),
    .last  (last)
  );

  // strobe windows
  logic [CNT_W-1:0] w_first [NWIN];
  logic [CNT_W-1:0] w_span  [NWIN];
  logic [NWIN-1:0]  w_en;
  logic [NWIN-1:0]  w_on;

  always_comb begin
    w_en[W_TXON]    = run && is_tx_q;
    w_first[W_TXON] = CNT_W'(TX_ON_TICKS);
    w_span[W_TXON]  = limit;

    w_en[W_LOOP]    = run && is_tx_q;
    w_first[W_LOOP] = CNT_W'(TX_ON_TICKS + LOOP_GAP);
    w_span[W_LOOP]  = limit;

    w_en[W_RXON]    = run && !is_tx_q;
    w_first[W_RXON] = CNT_W'(RX_ON_TICKS);
    w_span[W_RXON]  = limit;

    w_en[W_DATA]    = run;
    w_first[W_DATA] = is_tx_q ? CNT_W'(TX_DATA_AT) : CNT_W'(RX_DATA_AT);
    w_span[W_DATA]  = CNT_W'(data_ticks(len_q, DATA1_TICKS, DATA3_TICKS, DATA5_TICKS));

    w_en[W_SYNC]    = run && !is_tx_q;
    w_first[W_SYNC] = CNT_W'(RX_DATA_AT);
    w_span[W_SYNC]  = CNT_W'(SYNC_TICKS);
  end

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      rss_window #(.W(CNT_W)) u_win (
        .en    (w_en[g]),
        .pos   (pos),
        .first (w_first[g]),
        .span  (w_span[g]),
        .on    (w_on[g])
      );
    end
  endgenerate

  assign synth_en    = run;
  assign tx_en       = w_on[W_TXON];
  assign loop_open   = w_on[W_LOOP];
  assign rx_en       = w_on[W_RXON];
  assign data_ok     = w_on[W_DATA];
  assign pkt_strobe  = w_on[W_SYNC];
  assign rssi_sample = pkt_strobe && !pkt_d;
  assign slot_end    = last;
  assign busy        = (st != S_IDLE);
  assign start_err   = err_q;

  // R2: the slot begins only after the channel was reported loaded
  a_r2_synth_after_chan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synth_en) |-> $past(chan_loaded));

  // R4: loop opens only while transmitting
  a_r4_loop_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    loop_open |-> tx_en);

  // R5: never both directions
  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en));

  // R7: slot end clears everything on the next cycle
  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (!synth_en && !tx_en && !rx_en && !loop_open && !busy));

  // R8: sample pulse only at the packet strobe, inside receive
  a_r8_sample_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_sample |-> (pkt_strobe && rx_en));

  // R9: a start during a slot leaves it running and flags an error
  a_r9_reject_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !slot_end) |=> (busy && start_err));

  // R10: strobes imply busy
  a_r10_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (synth_en || tx_en || rx_en || pkt_strobe || data_ok) |-> busy);

endmodule

// File: tb/tb_rss_slot_sequencer.sv
module tb_rss_slot_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1us = 1'b0;
  logic       start = 1'b0;
  logic       slot_rx = 1'b0;
  logic [1:0] pkt_len = 2'd0;
  logic       chan_loaded = 1'b0;
  logic       synth_en, tx_en, loop_open, rx_en, pkt_strobe;
  logic       rssi_sample, data_ok, slot_end, busy, start_err;

  always #5 clk = ~clk;

  rss_slot_sequencer dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .start(start),
    .slot_rx(slot_rx), .pkt_len(pkt_len), .chan_loaded(chan_loaded),
    .synth_en(synth_en), .tx_en(tx_en), .loop_open(loop_open), .rx_en(rx_en),
    .pkt_strobe(pkt_strobe), .rssi_sample(rssi_sample), .data_ok(data_ok),
    .slot_end(slot_end), .busy(busy), .start_err(start_err)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  chk_on  = 1'b0;
  bit  tick_rand = 1'b0;
  bit  done = 1'b0;

  function automatic int ref_slot(input int code);
    case (code) 0: return 625; 1: return 1875; default: return 3125; endcase
  endfunction

  function automatic int ref_data(input int code);
    case (code) 0: return 366; 1: return 1622; default: return 2870; endcase
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 25)
        $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 waiting for channel, 2 running
  int m_st = 0, m_el = 0, m_len = 0;
  bit m_tx = 0, m_err = 0, m_pd = 0;

  function automatic bit e_pkt_f();
    return (m_st == 2) && !m_tx && (m_el >= 213) && (m_el < 213 + 72);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_len = 0; m_tx = 0; m_err = 0; m_pd = 0;
    end else begin
      m_pd  = e_pkt_f();
      m_err = start && ((m_st != 0) || (pkt_len == 2'd3));
      case (m_st)
        0: if (start && pkt_len != 2'd3) begin
             m_tx = !slot_rx; m_len = int'(pkt_len); m_el = 0;
             m_st = chan_loaded ? 2 : 1;
           end
        1: if (chan_loaded) begin m_st = 2; m_el = 0; end
        default: if (tick_1us) begin
             if (m_el == ref_slot(m_len) - 1) begin m_st = 0; m_el = 0; end
             else m_el++;
           end
      endcase
    end
  end

  // cycle-by-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      bit run; int ds;
      run = (m_st == 2);
      ds  = m_tx ? 214 : 213;
      check(synth_en, run, "R2 synth_en");
      check(tx_en, run && m_tx && m_el >= 110, "R3 tx_en");
      check(loop_open, run && m_tx && m_el >= 214, "R4 loop_open");
      check(rx_en, run && !m_tx && m_el >= 208, "R5 rx_en");
      check(data_ok, run && m_el >= ds && m_el < ds + ref_data(m_len), "R6 data_ok");
      check(slot_end, run && tick_1us && m_el == ref_slot(m_len) - 1, "R7 slot_end");
      check(pkt_strobe, e_pkt_f(), "R8 pkt_strobe");
      check(rssi_sample, e_pkt_f() && !m_pd, "R8 rssi_sample");
      check(start_err, m_err, "R9 start_err");
      check(busy, m_st != 0, "R10 busy");
    end
  end

  always @(negedge clk)
    if (tick_rand) tick_1us <= ($urandom % 2 == 0);

  // one slot; freeze > 0 stops ticks for that many cycles after tick 300
  task automatic do_slot(input bit rx, input int len, input int delay,
                         input int freeze, input bit spurious);
    @(negedge clk);
    start = 1'b1; slot_rx = rx; pkt_len = 2'(len); chan_loaded = (delay == 0);
    @(negedge clk);
    start = 1'b0;
    repeat (delay) @(negedge clk);
    chan_loaded = 1'b1;
    while (busy) begin
      @(negedge clk);
      if (freeze > 0 && m_st == 2 && m_el == 300) begin
        bit t0, l0, d0, ended;
        tick_rand = 1'b0; tick_1us = 1'b0;
        t0 = tx_en; l0 = loop_open; d0 = data_ok; ended = 1'b0;
        repeat (freeze) begin
          @(negedge clk); #2;
          if (slot_end) ended = 1'b1;
        end
        check(ended, 1'b0, "R11 no slot_end without ticks");
        check(tx_en, t0, "R11 tx_en frozen");
        check(loop_open, l0, "R11 loop_open frozen");
        check(data_ok, d0, "R11 data_ok frozen");
        check(synth_en, 1'b1, "R11 slot still active");
        freeze = 0; tick_rand = 1'b1;
      end
      if (spurious && busy && ($urandom % 400 == 0)) begin
        start = 1'b1; pkt_len = 2'($urandom % 4); slot_rx = $urandom % 2;
        @(negedge clk);
        start = 1'b0;
      end
    end
    chan_loaded = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    #2;
    check(synth_en, 1'b0, "R1 synth_en reset");
    check(tx_en,    1'b0, "R1 tx_en reset");
    check(rx_en,    1'b0, "R1 rx_en reset");
    check(busy,     1'b0, "R1 busy reset");
    check(start_err,1'b0, "R1 start_err reset");
    check(data_ok,  1'b0, "R1 data_ok reset");
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    tick_rand = 1'b1;

    // invalid length code while idle: R9
    @(negedge clk);
    start = 1'b1; pkt_len = 2'd3; slot_rx = 1'b0; chan_loaded = 1'b1;
    @(negedge clk);
    start = 1'b0; chan_loaded = 1'b0;
    #2;
    check(start_err, 1'b1, "R9 invalid length flagged");
    check(busy, 1'b0, "R9 invalid length ignored");
    repeat (2) @(negedge clk);

    // directed corners: each length both ways, one frozen-tick window
    do_slot(1'b0, 0, 0, 40, 1'b0);
    do_slot(1'b1, 0, 5, 0, 1'b0);
    do_slot(1'b0, 1, 2, 0, 1'b0);
    do_slot(1'b1, 2, 0, 25, 1'b0);

    // start while busy, directed: R9
    @(negedge clk);
    start = 1'b1; pkt_len = 2'd0; slot_rx = 1'b1; chan_loaded = 1'b1;
    @(negedge clk);
    start = 1'b1; pkt_len = 2'd2; slot_rx = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #2;
    check(start_err, 1'b1, "R9 start while busy flagged");
    check(busy, 1'b1, "R10 slot continues");
    while (busy) @(negedge clk);
    chan_loaded = 1'b0;

    // random slots
    for (int i = 0; i < 14; i++)
      do_slot($urandom % 2, $urandom % 3, $urandom % 6, 0, 1'b1);

    chk_on = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule